// File: doc/BRIEF.md
# Segmented Tapped Shift Register

This block is a serial shift register of 64 stages, built as four segments of 16 stages each. Data moves one stage per rising clock edge, from stage 1 toward stage 64. The last stage of every segment is brought out as a tap, so the register can serve as a delay line with outputs after 16, 32, 48 and 64 clocks.

A write-enable input selects how the segments are joined. With write-enable low, each segment feeds the next and the taps are driven outputs. With write-enable high, the three inner taps become serial inputs for segments 2 to 4, so all four segments load at once and the full register fills in 16 clocks. While write-enable is high, every tap output, including the bit-64 output, reports itself disabled. Pins that would be three-state are modelled as a separate tap input, a tap output and an output-enable flag. A dual-channel part is built from two instances.

Top module: `seg_tap_shreg`

## Requirements
- R1: The register has NUM_SEG*SEG_LEN stages (default 4 x 16 = 64); tap_out[k] always shows the last stage of segment k, so tap_out[0..3] are stages 16, 32, 48 and 64.
- R2: With wr_en low, the first stage of segment k+1 takes the last stage of segment k on each rising edge, so a bit driven on din appears on tap_out[3] after exactly 64 rising edges.
- R3: On every rising edge with rst low, stage 1 captures din, whatever the level of wr_en.
- R4: With wr_en high, the first stage of segment k (k = 1..3) captures tap_in[k-1] on each rising edge; 16 such edges load all 64 stages, and tap_out still carries the stage values.
- R5: Every bit of tap_oe equals the inverse of wr_en at all times (1 = driving, 0 = high impedance), following each change of wr_en without waiting for a clock edge.
- R6: Stage contents change only on a rising clock edge; while the clock is stopped the contents and tap_out hold indefinitely, whatever din, tap_in and wr_en do.
- R7: When rst is high at a rising edge, all stages clear to 0 and tap_out reads all zeros after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | 0: one chained delay line; 1: parallel segment load |
| din | input | 1 | Serial input to segment 0 |
| tap_in | input | NUM_SEG-1 | Serial inputs for segments 1..3 during load |
| tap_out | output | NUM_SEG | Last stage of each segment (bits 16, 32, 48, 64) |
| tap_oe | output | NUM_SEG | Drive flag for each tap, low while loading |

## Verification
The assertions take for granted that wr_en, din and tap_in are settled before each rising edge and that rst is raised for at least one edge before any check that looks into the past; the bench drives every input on the falling edge and opens with several reset cycles. They also assume tap_in carries defined values while wr_en is high, which the bench ensures by feeding it from a pattern generator at all times. The stimulus covers a single-bit pulse through the full chain, a 16-clock parallel load followed by a 64-clock serial readout, a stopped clock with toggling inputs, and write-enable edges in both directions.

// File: rtl/seg_shreg_pkg.sv
package seg_shreg_pkg;
  // How segment k>0 obtains its serial input.
  typedef enum logic {
    LINK_CHAIN = 1'b0,  // from the previous segment's last stage
    LINK_LOAD  = 1'b1   // from the matching tap input
  } link_mode_e;
endpackage

// File: rtl/shreg_seg.sv
module shreg_seg #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sin,
  output logic head,
  output logic tail
);
  logic [LEN-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q <= '0;
    else     stg_q <= {stg_q[LEN-2:0], sin};
  end

  assign head = stg_q[0];
  assign tail = stg_q[LEN-1];
endmodule

// File: rtl/seg_link_sel.sv
module seg_link_sel
  import seg_shreg_pkg::*;
#(
  parameter int NUM_SEG = 4
) (
  input  logic               wr_en,
  input  logic               din,
  input  logic [NUM_SEG-2:0] tap_in,
  input  logic [NUM_SEG-1:0] tails,
  output logic [NUM_SEG-1:0] seg_in,
  output logic [NUM_SEG-1:0] oe
);
  link_mode_e mode;
  assign mode = link_mode_e'(wr_en);

  assign seg_in[0] = din;

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_link
    always_comb begin
      unique case (mode)
        LINK_LOAD:  seg_in[k] = tap_in[k-1];
        default:    seg_in[k] = tails[k-1];
      endcase
    end
  end

  assign oe = (mode == LINK_CHAIN) ? '1 : '0;
endmodule

// File: rtl/seg_tap_shreg.sv
module seg_tap_shreg #(
  parameter int NUM_SEG = 4,
  parameter int SEG_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               din,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int TOTAL = NUM_SEG * SEG_LEN;

  logic [NUM_SEG-1:0] seg_in;
  logic [NUM_SEG-1:0] heads;
  logic [NUM_SEG-1:0] tails;

  seg_link_sel #(.NUM_SEG(NUM_SEG)) link_i (
    .wr_en  (wr_en),
    .din    (din),
    .tap_in (tap_in),
    .tails  (tails),
    .seg_in (seg_in),
    .oe     (tap_oe)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    shreg_seg #(.LEN(SEG_LEN)) seg_i (
      .clk  (clk),
      .rst  (rst),
      .sin  (seg_in[k]),
      .head (heads[k]),
      .tail (tails[k])
    );
  end

  assign tap_out = tails;

  // Assertion support: set once one clock has passed after reset.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_din_in_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> heads[0] == $past(din));

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_chk
    p_chain_r2: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(wr_en)) |-> heads[k] == $past(tails[k-1]));
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(wr_en)) |-> heads[k] == $past(tap_in[k-1]));
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> tap_out == '0);

  p_oe_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> tap_oe == '0);

  initial begin
    a_size_r1: assert (TOTAL == NUM_SEG * SEG_LEN && SEG_LEN > 1);
  end
endmodule

// File: tb/seg_tap_shreg_tb_top.sv
module seg_tap_shreg_tb_top;
  localparam int NS = 4;
  localparam int SL = 16;
  localparam int N  = NS * SL;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic din = 1'b0;
  logic [NS-2:0] tap_in = '0;
  logic [NS-1:0] tap_out;
  logic [NS-1:0] tap_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit model [N];
  bit snap [N];
  logic [15:0] lfsr = 16'hACE1;

  seg_tap_shreg #(.NUM_SEG(NS), .SEG_LEN(SL)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  always begin
    #2;
    if (clk_run) clk = ~clk;
  end

  // Behavioural reference: stage i (0-based) of one flat 64-bit line.
  always @(posedge clk) begin
    bit nxt [N];
    if (rst) begin
      foreach (model[i]) model[i] = 1'b0;
    end else begin
      for (int i = 1; i < N; i++) nxt[i] = model[i-1];
      nxt[0] = din;
      if (wr_en)
        for (int s = 1; s < NS; s++) nxt[s*SL] = tap_in[s-1];
      foreach (model[i]) model[i] = nxt[i];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NS-1:0] exp_tap;
    for (int s = 0; s < NS; s++) exp_tap[s] = model[(s+1)*SL-1];
    check("R1/R2/R3/R4 taps", 32'(tap_out), 32'(exp_tap));
    check("R5 output enables", 32'(tap_oe), wr_en ? 32'h0 : 32'hF);
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic tick(input logic w, input logic d, input logic [NS-2:0] ti);
    @(negedge clk);
    compare_all();
    wr_en = w; din = d; tap_in = ti;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset clears taps", 32'(tap_out), 32'h0);
    check("R5 oe with wr_en low", 32'(tap_oe), 32'hF);
    rst = 1'b0;

    // R2: single pulse travels the whole chain in 64 clocks.
    tick(1'b0, 1'b1, '0);
    for (int i = 0; i < N - 1; i++) tick(1'b0, 1'b0, '0);
    @(negedge clk);
    check("R2 pulse at bit 64 after 64 clocks", 32'(tap_out[NS-1]), 32'h1);
    check("R2 pulse gone from bit 48", 32'(tap_out[NS-2]), 32'h0);

    // Random serial stream, chained.
    for (int i = 0; i < 80; i++) begin
      next_rand();
      tick(1'b0, lfsr[0], lfsr[3:1]);
    end

    // R4: 16-clock parallel load, then R3/R2 serial readout.
    for (int i = 0; i < SL; i++) begin
      next_rand();
      tick(1'b1, lfsr[5], lfsr[8:6]);
    end
    @(negedge clk);
    compare_all();
    foreach (snap[i]) snap[i] = model[i];
    wr_en = 1'b0; din = 1'b0; tap_in = '1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      compare_all();
      check("R4 loaded bit read out at bit 64", 32'(tap_out[NS-1]), 32'(snap[N-2-i < 0 ? 0 : N-2-i] & (i < N-1)));
    end

    // R3: din captured during load mode too; R5 toggling.
    for (int i = 0; i < 40; i++) begin
      next_rand();
      tick(lfsr[2] & lfsr[4], lfsr[0], lfsr[9:7]);
    end

    // R6: stop the clock and wiggle inputs.
    @(negedge clk);
    compare_all();
    begin
      logic [NS-1:0] held;
      held = tap_out;
      clk_run = 1'b0;
      for (int i = 0; i < 10; i++) begin
        next_rand();
        wr_en = lfsr[1]; din = lfsr[0]; tap_in = lfsr[4:2];
        #5;
        check("R6 taps hold with clock stopped", 32'(tap_out), 32'(held));
      end
      wr_en = 1'b0;
      #1;
      clk_run = 1'b1;
    end
    for (int i = 0; i < 20; i++) begin
      next_rand();
      tick(1'b0, lfsr[0], lfsr[3:1]);
    end

    // R7: reset from a loaded state.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset clears loaded taps", 32'(tap_out), 32'h0);
    rst = 1'b0;
    tick(1'b0, 1'b0, '0);
    tick(1'b0, 1'b0, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule